// File: doc/BRIEF.md
# Divide-Ratio Realisability Checker

This block decides whether a feedback divide ratio N can actually be produced by a two-modulus prescaler divider. It is given a modulus P of 5 or 10, and a dither mode. The mode is integer, 2nd-order fractional or 3rd-order fractional. The divider splits N into a main count M and a swallow count A. A given instantaneous ratio works only when the swallow count does not exceed M+1 and the main count is at least one. A fractional loop does not request only N. Its noise shaper moves the instantaneous ratio around N, so every ratio it may reach must also be realisable.

A request is accepted with a one-cycle start pulse while the block is idle. When N is at or above the contiguous threshold for the chosen P and mode, the answer comes back on the next cycle. Otherwise the block walks through the dithered ratios, testing one of them each clock. When it finishes, it raises a one-cycle done strobe with the verdict. Along with the verdict it gives the M and A split of the nominal N. These results hold until the next done strobe.

Top module: `divratio_check`

## Requirements
- R1: At each done pulse, m_o equals floor(N/P)-1 modulo 2^NW and a_o equals N-P*floor(N/P), for the accepted N. Both outputs hold their values between done pulses.
- R2: A candidate ratio c is realisable exactly when c >= 0, floor(c/P) >= 2 (so M >= 1), and c mod P <= floor(c/P) (so A <= M+1). A valid verdict therefore implies that the nominal M and A meet this rule.
- R3: In integer mode (mode_i = 0), valid_o is 1 exactly when N itself is realisable.
- R4: In 2nd-order mode (mode_i = 1), valid_o is 1 exactly when every ratio from N-1 up to N+2 is realisable.
- R5: In 3rd-order mode (mode_i = 2), valid_o is 1 exactly when every ratio from N-3 up to N+4 is realisable.
- R6: Suppose N is at least P*P-P in integer mode, P*P-P+1 in 2nd-order mode, or P*P-P+3 in 3rd-order mode. Then done_o and valid_o = 1 appear one cycle after the start cycle.
- R7: Below that threshold, done_o appears 2, 5 or 9 cycles after the start cycle in integer, 2nd-order and 3rd-order mode respectively. This is one cycle per candidate tested, plus the accept cycle. done_o lasts a single cycle.
- R8: busy_o is high from the cycle after an accept that goes below the threshold until the done pulse. A start pulse while busy_o is high is ignored: it does not change the verdict, the M/A outputs or the timing of the running check.
- R9: mode_i = 3 behaves as integer mode.
- R10: sel10_i = 0 selects P = 5, and sel10_i = 1 selects P = 10.
- R11: After reset, done_o, busy_o and valid_o are 0, and m_o and a_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| n_i | input | NW | Requested nominal divide ratio |
| sel10_i | input | 1 | Modulus select: 0 gives P=5, 1 gives P=10 |
| mode_i | input | 2 | 0 integer, 1 2nd-order, 2 3rd-order, 3 integer |
| busy_o | output | 1 | Candidate scan in progress |
| done_o | output | 1 | One-cycle verdict strobe |
| valid_o | output | 1 | Verdict: all required ratios realisable |
| m_o | output | NW | Main count for the nominal N |
| a_o | output | NW | Swallow count for the nominal N |

## Verification
The bench sweeps N from 0 to 130 for both moduli and all four mode codes. This covers the region below P where M goes negative, the sparse region where realisability changes from one N to the next, the edge of each contiguous threshold, and a stretch well above it that takes the fast path. Comparing the verdict across the three dither orders for the same N separates a design that tests only N from one that tests the whole window, and shows whether an off-by-one in the window bounds is present. Latency is measured for every request, which tells the fast path apart from the scan path. A separate run issues a competing start pulse during a scan, to show that the scan in progress keeps its result.

// File: rtl/dr_pkg.sv
package dr_pkg;
    localparam logic [1:0] MODE_INT = 2'd0;
    localparam logic [1:0] MODE_FR2 = 2'd1;
    localparam logic [1:0] MODE_FR3 = 2'd2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } dr_state_e;
endpackage

// File: rtl/dr_split.sv
// Splits a ratio into quotient and remainder by the selected modulus.
module dr_split #(
    parameter int W    = 12,
    parameter int P_LO = 5,
    parameter int P_HI = 10
) (
    input  logic [W-1:0] val_i,
    input  logic         sel_hi_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam logic [W-1:0] PL = W'(P_LO);
    localparam logic [W-1:0] PH = W'(P_HI);

    logic [W-1:0] q_lo, q_hi, p_sel;

    always_comb begin
        q_lo  = val_i / PL;
        q_hi  = val_i / PH;
        quo_o = sel_hi_i ? q_hi : q_lo;
        p_sel = sel_hi_i ? PH : PL;
        rem_o = val_i - quo_o * p_sel;
    end
endmodule

// File: rtl/dr_rule.sv
// Realisability rule: M = quo-1 >= 1 and A = rem <= M+1 = quo.
module dr_rule #(
    parameter int W = 12
) (
    input  logic         neg_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] rem_i,
    output logic         ok_o
);
    localparam logic [W-1:0] TWO = W'(2);

    always_comb begin
        ok_o = !neg_i && (quo_i >= TWO) && (rem_i <= quo_i);
    end
endmodule

// File: rtl/dr_window.sv
// Contiguous threshold, lower offset and candidate count per mode.
module dr_window #(
    parameter int W    = 10,
    parameter int P_LO = 5,
    parameter int P_HI = 10
) (
    input  logic         sel_hi_i,
    input  logic [1:0]   mode_i,
    output logic [W-1:0] nmin_o,
    output logic [1:0]   lo_o,
    output logic [3:0]   span_o
);
    import dr_pkg::*;

    localparam int BASE_LO = P_LO * P_LO - P_LO;
    localparam int BASE_HI = P_HI * P_HI - P_HI;

    logic [W-1:0] base;

    always_comb begin
        base = sel_hi_i ? W'(BASE_HI) : W'(BASE_LO);
        case (mode_i)
            MODE_FR2: begin
                nmin_o = base + W'(1);
                lo_o   = 2'd1;
                span_o = 4'd4;
            end
            MODE_FR3: begin
                nmin_o = base + W'(3);
                lo_o   = 2'd3;
                span_o = 4'd8;
            end
            default: begin
                nmin_o = base;
                lo_o   = 2'd0;
                span_o = 4'd1;
            end
        endcase
    end
endmodule

// File: rtl/divratio_check.sv
module divratio_check #(
    parameter int NW   = 10,
    parameter int P_LO = 5,
    parameter int P_HI = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [NW-1:0] n_i,
    input  logic          sel10_i,
    input  logic [1:0]    mode_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          valid_o,
    output logic [NW-1:0] m_o,
    output logic [NW-1:0] a_o
);
    import dr_pkg::*;

    localparam int CW = NW + 2;

    typedef struct packed {
        dr_state_e     state;
        logic          sel10;
        logic [CW-1:0] cand;
        logic [3:0]    left;
        logic          ok;
        logic [NW-1:0] pend_m;
        logic [NW-1:0] pend_a;
        logic          done;
        logic          valid;
        logic [NW-1:0] m;
        logic [NW-1:0] a;
    } dr_reg_t;

    dr_reg_t st_d, st_q;

    // nominal split of the incoming request
    logic [NW-1:0] nom_quo, nom_rem, nom_m;
    dr_split #(.W(NW), .P_LO(P_LO), .P_HI(P_HI)) u_nom (
        .val_i    (n_i),
        .sel_hi_i (sel10_i),
        .quo_o    (nom_quo),
        .rem_o    (nom_rem)
    );
    assign nom_m = nom_quo - NW'(1);

    // window for the incoming request
    logic [NW-1:0] win_nmin;
    logic [1:0]    win_lo;
    logic [3:0]    win_span;
    dr_window #(.W(NW), .P_LO(P_LO), .P_HI(P_HI)) u_win (
        .sel_hi_i (sel10_i),
        .mode_i   (mode_i),
        .nmin_o   (win_nmin),
        .lo_o     (win_lo),
        .span_o   (win_span)
    );

    // test of the current candidate
    logic          cand_neg, cand_ok;
    logic [CW-1:0] cand_mag, cand_quo, cand_rem;
    assign cand_neg = st_q.cand[CW-1];
    assign cand_mag = cand_neg ? '0 : st_q.cand;

    dr_split #(.W(CW), .P_LO(P_LO), .P_HI(P_HI)) u_cand (
        .val_i    (cand_mag),
        .sel_hi_i (st_q.sel10),
        .quo_o    (cand_quo),
        .rem_o    (cand_rem)
    );

    dr_rule #(.W(CW)) u_rule (
        .neg_i (cand_neg),
        .quo_i (cand_quo),
        .rem_i (cand_rem),
        .ok_o  (cand_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.sel10  = sel10_i;
                    st_d.pend_m = nom_m;
                    st_d.pend_a = nom_rem;
                    if (n_i >= win_nmin) begin
                        st_d.done  = 1'b1;
                        st_d.valid = 1'b1;
                        st_d.m     = nom_m;
                        st_d.a     = nom_rem;
                    end else begin
                        st_d.state = ST_SCAN;
                        st_d.cand  = {2'b00, n_i} - {{(CW-2){1'b0}}, win_lo};
                        st_d.left  = win_span - 4'd1;
                        st_d.ok    = 1'b1;
                    end
                end
            end
            default: begin
                if (st_q.left == 4'd0) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                    st_d.valid = st_q.ok && cand_ok;
                    st_d.m     = st_q.pend_m;
                    st_d.a     = st_q.pend_a;
                end else begin
                    st_d.ok   = st_q.ok && cand_ok;
                    st_d.cand = st_q.cand + CW'(1);
                    st_d.left = st_q.left - 4'd1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // registered modulus select, observed by the bound checker
    logic sel10_q;
    assign sel10_q = st_q.sel10;

    assign busy_o  = (st_q.state == ST_SCAN);
    assign done_o  = st_q.done;
    assign valid_o = st_q.valid;
    assign m_o     = st_q.m;
    assign a_o     = st_q.a;
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
    parameter int NW   = 10,
    parameter int P_LO = 5,
    parameter int P_HI = 10
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          valid_o,
    input logic [NW-1:0] m_o,
    input logic [NW-1:0] a_o,
    input logic          sel10_q
);
    logic [4:0] busy_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= (busy_run == 5'd31) ? busy_run : busy_run + 5'd1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R8

    AST_ACCEPT_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (done_o || busy_o)); // R7

    AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(valid_o) && $stable(m_o) && $stable(a_o))); // R1

    AST_VALID_NOMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && valid_o) |-> ((m_o != '1) && (m_o >= NW'(1))
                                 && ({1'b0, a_o} <= {1'b0, m_o} + (NW+1)'(1)))); // R2

    AST_REM_BELOW_P: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (a_o < (sel10_q ? NW'(P_HI) : NW'(P_LO)))); // R10

    AST_SCAN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_run <= 5'd8); // R7
endmodule

bind divratio_check dr_checker #(.NW(NW), .P_LO(P_LO), .P_HI(P_HI)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .valid_o (valid_o),
    .m_o     (m_o),
    .a_o     (a_o),
    .sel10_q (sel10_q)
);

// File: tb/sim_divratio_check.sv
module sim_divratio_check;
    localparam int NW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] n = '0;
    logic          sel10 = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          busy, done, valid;
    logic [NW-1:0] m, a;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk; // 125 MHz

    divratio_check #(.NW(NW)) u0 (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .n_i (n),
        .sel10_i (sel10), .mode_i (mode), .busy_o (busy), .done_o (done),
        .valid_o (valid), .m_o (m), .a_o (a)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit realisable(input int c, input int p); // R2
        if (c < 0) return 1'b0;
        return (c / p >= 2) && (c % p <= c / p);
    endfunction

    function automatic int lo_of(input int md);
        return (md == 1) ? 1 : (md == 2) ? 3 : 0;
    endfunction

    function automatic int hi_of(input int md);
        return (md == 1) ? 2 : (md == 2) ? 4 : 0;
    endfunction

    function automatic bit exp_valid(input int nn, input int p, input int md);
        bit r = 1'b1;
        for (int c = nn - lo_of(md); c <= nn + hi_of(md); c++)
            r &= realisable(c, p);
        return r;
    endfunction

    function automatic int exp_latency(input int nn, input int p, input int md);
        int thr = p * p - p + lo_of(md);
        if (nn >= thr) return 1;                      // R6
        return (md == 1) ? 5 : (md == 2) ? 9 : 2;     // R7
    endfunction

    task automatic request(input int nn, input bit s10, input int md, output int lat);
        @(negedge clk);
        n = NW'(nn); sel10 = s10; mode = 2'(md); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic one_case(input int nn, input bit s10, input int md);
        int p = s10 ? 10 : 5;
        int lat;
        int q = nn / p;
        string tag;
        request(nn, s10, md, lat);
        tag = (md == 1) ? "R4" : (md == 2) ? "R5" : (md == 3) ? "R9" : "R3";
        chk(tag, int'(valid), int'(exp_valid(nn, p, md)));
        chk("R7", lat, exp_latency(nn, p, md));
        chk("R1_m", int'(m), (q - 1) & ((1 << NW) - 1));
        chk("R10_a", int'(a), nn - p * q);
        @(negedge clk);
        chk("R7_pulse", int'(done), 0);
        chk("R8_idle", int'(busy), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11_done", int'(done), 0);
        chk("R11_busy", int'(busy), 0);
        chk("R11_valid", int'(valid), 0);
        chk("R11_m", int'(m), 0);
        chk("R11_a", int'(a), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // known points: P=10, N=45 integer invalid, M=3, A=5
        request(45, 1'b1, 0, lat);
        chk("R3_n45", int'(valid), 0);
        chk("R1_n45m", int'(m), 3);
        chk("R1_n45a", int'(a), 5);
        // P=10, N=90 in 2nd order invalid (89 fails)
        request(90, 1'b1, 1, lat);
        chk("R4_n90", int'(valid), 0);
        request(91, 1'b1, 1, lat);
        chk("R6_n91", int'(valid), 1);
        chk("R6_n91lat", lat, 1);

        // sweep
        for (int s = 0; s < 2; s++)
            for (int md = 0; md < 4; md++)
                for (int nn = 0; nn <= 130; nn++)
                    one_case(nn, s[0], md);

        // R8: start during a scan is ignored
        @(negedge clk);
        n = NW'(50); sel10 = 1'b1; mode = 2'd2; start = 1'b1;
        @(negedge clk);
        n = NW'(95); mode = 2'd0; start = 1'b1;   // competing request
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk("R8_lat", lat, 9);
        chk("R8_valid", int'(valid), int'(exp_valid(50, 10, 2)));
        chk("R8_m", int'(m), 4);
        chk("R8_a", int'(a), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule